// File: doc/BRIEF.md
# Quad Edge-Event Counter with Pair Cascading

This block counts edges on four external input pins with four 8-bit counters. The pins are synchronised and then edge-detected. Each counter has its own enable bit and its own 2-bit edge selection, so it can count rising edges, falling edges, both kinds, or nothing. Software reads and writes the counts, and the configuration, through a small flat register port. Writes take effect on the next clock edge. Reads are combinational.

Two neighbouring counters can be joined into one 16-bit counter. Counters 3 and 2 form one pair and counters 1 and 0 form the other, with the odd counter as the high byte. When a pair is joined, the high byte advances only on a carry out of the low byte. Each counter raises a sticky wrap flag when it rolls over, and an interrupt line reports any flag whose enable bit is set.

Top module: `quad_event_counter`

## Requirements
- R1: After reset, all four counts, the control register, the edge-select register, the wrap flags, the interrupt enables and `irq_o` are zero.
- R2: Counter n changes on an edge of pin n only while control bit n (register address 4, bits 3:0) is 1. While that bit is 0, the pin's edges leave the count unchanged.
- R3: The edge select for counter n is bits 2n+1:2n of register address 5. The codes are 00 (no edge counted), 01 (rising), 10 (falling) and 11 (both edges). Each qualifying edge adds exactly one.
- R4: Control bit 4 joins counters 3 and 2, and control bit 5 joins counters 1 and 0. In a joined pair, the even counter counts its pin as usual. The odd counter increments only when the even counter wraps from 0xFF to 0x00, and the odd counter's own pin and enable bit have no effect.
- R5: Every counter wraps from 0xFF to 0x00 and then sets its wrap flag (address 6, bit n). A flag stays set until software writes 1 to its bit at address 6. Writing 0 to a bit leaves that flag alone. A wrap in the same cycle as the clearing write leaves the flag set.
- R6: `irq_o` is 1 exactly when some wrap flag is set and the matching bit of address 7 is 1.
- R7: A write to count address n (0 to 3) loads the written value even if a counted edge arrives in the same cycle. That edge is lost, and no carry leaves the written counter.
- R8: A pin change is counted on the third rising clock edge after it. The count does not yet show the change after two edges, and does show it after three.
- R9: Addresses 0 to 3 read back the counts. Address 4 reads the control bits, address 5 the edge selects, address 6 the flags and address 7 the interrupt enables, with unused bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 4 | Asynchronous event inputs, one per counter |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | CNT_W | Combinational read data |
| irq_o | output | 1 | Interrupt request from enabled wrap flags |

## Verification
A wrong synchroniser or previous-sample bit shows up as a spurious or missing count. That error can be read back on the third clock edge after the pin change. A corrupted counter byte is visible on the very next read of its address. In a joined pair the damage spreads into the high byte at the next wrap. A wrong wrap flag moves `irq_o` in the same cycle, provided its enable bit is set, so the bench checks the interrupt line after every stimulus step as well as reading the flag register.

// File: rtl/qec_pkg.sv
`timescale 1ns/1ps
package qec_pkg;
    localparam int NUM_CH   = 4;
    localparam int NUM_PAIR = NUM_CH / 2;
    localparam int REG_AW   = 3;
    localparam int SEL_W    = 2;
    localparam int CFG_W    = NUM_CH + NUM_PAIR;

    typedef enum logic [SEL_W-1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    localparam logic [REG_AW-1:0] ADDR_CTRL = 3'd4;
    localparam logic [REG_AW-1:0] ADDR_EDGE = 3'd5;
    localparam logic [REG_AW-1:0] ADDR_FLAG = 3'd6;
    localparam logic [REG_AW-1:0] ADDR_IE   = 3'd7;

    // control bit that joins pair p (pair 1 = counters 3:2, pair 0 = counters 1:0)
    localparam int JOIN_BIT_PAIR1 = 4;
    localparam int JOIN_BIT_PAIR0 = 5;
endpackage

// File: rtl/qec_edge_detect.sv
`timescale 1ns/1ps
module qec_edge_detect
    import qec_pkg::*;
#(
    parameter int NCH    = NUM_CH,
    parameter int STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       pin_i,
    input  logic [NCH*SEL_W-1:0] sel_i,
    output logic [NCH-1:0]       event_o
);
    typedef struct packed {
        logic [NCH-1:0][STAGES-1:0] sync;
        logic [NCH-1:0]             prev;
    } det_t;

    det_t det_d, det_q;
    logic [NCH-1:0] cur;

    always_comb begin
        det_d = det_q;
        for (int c = 0; c < NCH; c++) begin
            det_d.sync[c] = {det_q.sync[c][STAGES-2:0], pin_i[c]};
            det_d.prev[c] = det_q.sync[c][STAGES-1];
        end
    end

    always_comb begin
        event_o = '0;
        for (int c = 0; c < NCH; c++) begin
            cur[c] = det_q.sync[c][STAGES-1];
            case (edge_sel_e'(sel_i[c*SEL_W +: SEL_W]))
                EDGE_RISE: event_o[c] = cur[c] & ~det_q.prev[c];
                EDGE_FALL: event_o[c] = ~cur[c] & det_q.prev[c];
                EDGE_BOTH: event_o[c] = cur[c] ^ det_q.prev[c];
                default:   event_o[c] = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R3: a rising-edge event cannot repeat in the next cycle
        a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
            (event_o[g] && sel_i[g*SEL_W +: SEL_W] == EDGE_RISE)
            |=> !(event_o[g] && sel_i[g*SEL_W +: SEL_W] == EDGE_RISE));
        // R3: code 00 never produces an event
        a_r3_none_silent: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_i[g*SEL_W +: SEL_W] == EDGE_NONE) |-> !event_o[g]);
    end
endmodule

// File: rtl/qec_counter_bank.sv
`timescale 1ns/1ps
module qec_counter_bank
    import qec_pkg::*;
#(
    parameter int NCH   = NUM_CH,
    parameter int CNT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0]            event_i,
    input  logic [NCH-1:0]            en_i,
    input  logic [NCH/2-1:0]          join_i,
    input  logic [NCH-1:0]            wr_i,
    input  logic [CNT_W-1:0]          wr_data_i,
    output logic [NCH-1:0][CNT_W-1:0] cnt_o,
    output logic [NCH-1:0]            wrap_o
);
    localparam int NPAIR = NCH / 2;

    typedef struct packed {
        logic [NCH-1:0][CNT_W-1:0] cnt;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NCH-1:0] inc, wrap;

    always_comb begin
        bank_d = bank_q;
        inc    = '0;
        wrap   = '0;
        for (int p = 0; p < NPAIR; p++) begin
            inc[2*p]    = event_i[2*p] & en_i[2*p];
            wrap[2*p]   = inc[2*p] & (bank_q.cnt[2*p] == '1) & ~wr_i[2*p];
            inc[2*p+1]  = join_i[p] ? wrap[2*p] : (event_i[2*p+1] & en_i[2*p+1]);
            wrap[2*p+1] = inc[2*p+1] & (bank_q.cnt[2*p+1] == '1) & ~wr_i[2*p+1];
        end
        for (int c = 0; c < NCH; c++) begin
            if (wr_i[c])     bank_d.cnt[c] = wr_data_i;
            else if (inc[c]) bank_d.cnt[c] = bank_q.cnt[c] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign cnt_o  = bank_q.cnt;
    assign wrap_o = wrap;

    for (genvar p = 0; p < NPAIR; p++) begin : g_chk
        // R2: a disabled, unwritten low counter holds its value
        a_r2_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_i[2*p] && !wr_i[2*p]) |=> bank_q.cnt[2*p] == $past(bank_q.cnt[2*p]));
        // R2: a disabled, unwritten, unjoined high counter holds its value
        a_r2_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_i[2*p+1] && !wr_i[2*p+1] && !join_i[p])
            |=> bank_q.cnt[2*p+1] == $past(bank_q.cnt[2*p+1]));
        // R4: when joined, the high byte moves only after the low byte was 0xFF
        a_r4_carry_only: assert property (@(posedge clk) disable iff (!rst_n)
            (join_i[p] && !wr_i[2*p+1])
            |=> (bank_q.cnt[2*p+1] == $past(bank_q.cnt[2*p+1]))
                || ($past(bank_q.cnt[2*p]) == {CNT_W{1'b1}}));
    end
endmodule

// File: rtl/quad_event_counter.sv
`timescale 1ns/1ps
module quad_event_counter
    import qec_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        pin_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic [2:0]        rd_addr_i,
    output logic [CNT_W-1:0]  rd_data_o,
    output logic              irq_o
);
    localparam int SELS_W = NUM_CH * SEL_W;

    typedef struct packed {
        logic [NUM_CH-1:0]   en;
        logic [NUM_PAIR-1:0] join_p;
        logic [SELS_W-1:0]   sel;
        logic [NUM_CH-1:0]   flag;
        logic [NUM_CH-1:0]   ie;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [NUM_CH-1:0]             events;
    logic [NUM_CH-1:0]             wraps;
    logic [NUM_CH-1:0]             wr_cnt;
    logic [NUM_CH-1:0][CNT_W-1:0]  counts;
    logic [NUM_CH-1:0]             flag_clr;

    qec_edge_detect #(.NCH(NUM_CH), .STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .sel_i   (cfg_q.sel),
        .event_o (events)
    );

    qec_counter_bank #(.NCH(NUM_CH), .CNT_W(CNT_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_i   (events),
        .en_i      (cfg_q.en),
        .join_i    (cfg_q.join_p),
        .wr_i      (wr_cnt),
        .wr_data_i (wr_data_i),
        .cnt_o     (counts),
        .wrap_o    (wraps)
    );

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            wr_cnt[c] = wr_en_i && (wr_addr_i == REG_AW'(c));
        end
        flag_clr = (wr_en_i && wr_addr_i == ADDR_FLAG) ? wr_data_i[NUM_CH-1:0] : '0;
    end

    always_comb begin
        cfg_d      = cfg_q;
        cfg_d.flag = (cfg_q.flag & ~flag_clr) | wraps;
        if (wr_en_i) begin
            case (wr_addr_i)
                ADDR_CTRL: begin
                    cfg_d.en        = wr_data_i[NUM_CH-1:0];
                    cfg_d.join_p[1] = wr_data_i[JOIN_BIT_PAIR1];
                    cfg_d.join_p[0] = wr_data_i[JOIN_BIT_PAIR0];
                end
                ADDR_EDGE: cfg_d.sel = wr_data_i[SELS_W-1:0];
                ADDR_IE:   cfg_d.ie  = wr_data_i[NUM_CH-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            ADDR_CTRL: rd_data_o[CFG_W-1:0]  = {cfg_q.join_p[0], cfg_q.join_p[1], cfg_q.en};
            ADDR_EDGE: rd_data_o[SELS_W-1:0] = cfg_q.sel;
            ADDR_FLAG: rd_data_o[NUM_CH-1:0] = cfg_q.flag;
            ADDR_IE:   rd_data_o[NUM_CH-1:0] = cfg_q.ie;
            default:   rd_data_o = counts[rd_addr_i[1:0]];
        endcase
    end

    assign irq_o = |(cfg_q.flag & cfg_q.ie);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R5: a wrap sets the flag in the following cycle
        a_r5_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            wraps[g] |=> cfg_q.flag[g]);
        // R5: a set flag stays set unless a 1 is written to its bit
        a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q.flag[g] && !(wr_en_i && wr_addr_i == ADDR_FLAG && wr_data_i[g]))
            |=> cfg_q.flag[g]);
        // R7: a count write always lands, whatever else happens that cycle
        a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_addr_i == REG_AW'(g)) |=> counts[g] == $past(wr_data_i));
    end
endmodule

// File: tb/quad_event_counter_tb.sv
`timescale 1ns/1ps
module quad_event_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_i = '0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [2:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0] m_cnt [4];
    logic [3:0] m_flag, m_en, m_ie, m_pins;
    logic [1:0] m_join;   // [1] = counters 3:2, [0] = counters 1:0
    logic [7:0] m_sel;

    quad_event_counter u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    always #2 clk = ~clk;

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_addr_i = a;
        #1;
        v = rd_data_o;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    function automatic bit hit(input logic [1:0] s, input logic o, input logic n);
        case (s)
            2'b01:   return !o && n;
            2'b10:   return o && !n;
            2'b11:   return o != n;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_update(input logic [3:0] np);
        logic [3:0] ev;
        logic lo_wrap, hi_inc;
        for (int c = 0; c < 4; c++) ev[c] = m_en[c] && hit(m_sel[2*c +: 2], m_pins[c], np[c]);
        for (int p = 0; p < 2; p++) begin
            lo_wrap = 1'b0;
            if (ev[2*p]) begin
                if (m_cnt[2*p] == 8'hFF) begin lo_wrap = 1'b1; m_flag[2*p] = 1'b1; end
                m_cnt[2*p] = m_cnt[2*p] + 8'd1;
            end
            hi_inc = m_join[p] ? lo_wrap : ev[2*p+1];
            if (hi_inc) begin
                if (m_cnt[2*p+1] == 8'hFF) m_flag[2*p+1] = 1'b1;
                m_cnt[2*p+1] = m_cnt[2*p+1] + 8'd1;
            end
        end
        m_pins = np;
    endtask

    task automatic step(input logic [3:0] np);
        @(negedge clk);
        pin_i = np;
        repeat (5) @(negedge clk);
        model_update(np);
    endtask

    task automatic set_cfg(input logic [3:0] en, input logic [1:0] jn, input logic [7:0] sel, input logic [3:0] ie);
        wr(3'd4, {2'b00, jn[0], jn[1], en});
        wr(3'd5, sel);
        wr(3'd7, {4'h0, ie});
        m_en = en; m_join = jn; m_sel = sel; m_ie = ie;
    endtask

    task automatic set_cnt(input int n, input logic [7:0] v);
        wr(3'(n), v);
        m_cnt[n] = v;
    endtask

    task automatic check_all(input string req);
        logic [7:0] v;
        for (int c = 0; c < 4; c++) begin
            rd(3'(c), v);
            chk(req, $sformatf("count%0d", c), v, m_cnt[c]);
        end
        rd(3'd6, v);
        chk("R5", "flags", v, {4'h0, m_flag});
        chk("R6", "irq", {7'h0, irq_o}, {7'h0, |(m_flag & m_ie)});
    endtask

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        for (int c = 0; c < 4; c++) m_cnt[c] = '0;
        m_flag = '0; m_en = '0; m_ie = '0; m_pins = '0; m_join = '0; m_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and R9 readback of config registers
        check_all("R1");
        for (int a = 4; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1", $sformatf("reg%0d", a), v, 8'h00);
        end
        set_cfg(4'b1010, 2'b01, 8'b1110_0100, 4'b0101);
        rd(3'd4, v); chk("R9", "ctrl readback", v, 8'h2A);
        rd(3'd5, v); chk("R9", "edge readback", v, 8'hE4);
        rd(3'd7, v); chk("R9", "ie readback",   v, 8'h05);
        set_cfg(4'h0, 2'b00, 8'h00, 4'h0);

        // R8 latency: counted on the third clock edge
        set_cfg(4'b0001, 2'b00, 8'b0000_0001, 4'h0);
        @(negedge clk); pin_i = 4'b0001;
        @(posedge clk); @(posedge clk);
        @(negedge clk); #1; rd_addr_i = 3'd0; #0.5;
        chk("R8", "count0 after two edges", rd_data_o, 8'h00);
        @(negedge clk); #1;
        chk("R8", "count0 after three edges", rd_data_o, 8'h01);
        repeat (3) @(negedge clk);
        model_update(4'b0001);

        // R3 edge modes on counter 0
        step(4'b0000); check_all("R3");               // rising only: fall ignored
        set_cfg(4'b0001, 2'b00, 8'b0000_0010, 4'h0);  // falling
        step(4'b0001); check_all("R3");
        step(4'b0000); check_all("R3");
        set_cfg(4'b0001, 2'b00, 8'b0000_0011, 4'h0);  // both
        step(4'b0001); step(4'b0000); check_all("R3");
        set_cfg(4'b0001, 2'b00, 8'b0000_0000, 4'h0);  // none
        step(4'b0001); step(4'b0000); check_all("R3");

        // R2 disabled counter ignores edges
        set_cfg(4'b0000, 2'b00, 8'hFF, 4'h0);
        step(4'b1111); step(4'b0000); check_all("R2");

        // R4 cascade counters 3:2, pin 3 ignored
        set_cfg(4'b1100, 2'b10, 8'b1111_0000, 4'h0);
        set_cnt(2, 8'hFE); set_cnt(3, 8'h10);
        step(4'b1100); step(4'b0000); step(4'b1100);
        check_all("R4");
        set_cnt(2, 8'hFF); set_cnt(3, 8'hFF);
        step(4'b0000); check_all("R4");               // 16-bit wrap sets both flags
        // R4 cascade counters 1:0
        set_cfg(4'b0011, 2'b01, 8'b0000_1111, 4'h0);
        set_cnt(0, 8'hFF); set_cnt(1, 8'h7F);
        step(4'b0011); check_all("R4");

        // R5 writing 0 keeps flags, writing 1 clears one flag
        wr(3'd6, 8'h00); check_all("R5");
        wr(3'd6, 8'h04); m_flag[2] = 1'b0; check_all("R5");
        // R6 interrupt follows enable
        set_cfg(4'b0011, 2'b01, 8'b0000_1111, 4'b1000); check_all("R6");
        set_cfg(4'b0011, 2'b01, 8'b0000_1111, 4'b0000); check_all("R6");
        wr(3'd6, 8'h0F); m_flag = '0; check_all("R5");

        // R5 wrap in the same cycle as the clearing write keeps the flag
        set_cfg(4'b0001, 2'b00, 8'b0000_0011, 4'h1);
        set_cnt(0, 8'hFF);
        @(negedge clk); pin_i = 4'b0000;
        @(negedge clk);
        @(negedge clk); wr_en_i = 1'b1; wr_addr_i = 3'd6; wr_data_i = 8'h01;
        @(negedge clk); wr_en_i = 1'b0;
        repeat (3) @(negedge clk);
        model_update(4'b0000);
        check_all("R5");

        // R7 count write beats a same-cycle edge
        set_cfg(4'b0010, 2'b00, 8'b0000_0100, 4'h1);
        @(negedge clk); pin_i = 4'b0010;
        @(negedge clk);
        @(negedge clk); wr_en_i = 1'b1; wr_addr_i = 3'd1; wr_data_i = 8'h55;
        @(negedge clk); wr_en_i = 1'b0;
        repeat (3) @(negedge clk);
        m_pins = 4'b0010; m_cnt[1] = 8'h55;
        check_all("R7");

        // random phase
        for (int it = 0; it < 200; it++) begin
            if (it % 20 == 0) begin
                set_cfg(4'($urandom), 2'($urandom), 8'($urandom), 4'($urandom));
                for (int c = 0; c < 4; c++)
                    set_cnt(c, ($urandom % 2) ? 8'($urandom_range(8'hF8, 8'hFF)) : 8'($urandom));
            end
            if (it % 7 == 3) begin
                v = 8'($urandom) & 8'h0F;
                wr(3'd6, v);
                m_flag = m_flag & ~v[3:0];
            end
            step(4'($urandom));
            check_all(m_join != 0 ? "R4" : "R3");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule